// File: doc/BRIEF.md
# Reference-Window Clock Frequency Checker

This block watches a target clock and decides whether it runs at the expected rate. It uses a slow, always-on reference clock to set the measurement window. Each window lasts one reference period. During that window the block counts rising edges of the target clock. The count crosses into the reference domain through a toggle handshake. There it is compared against a programmed lower and upper bound, and each finished measurement is graded as okay, slow or fast.

Every error is latched in a sticky flag, and each error event also produces a one-cycle recoverable alert pulse. A separate watchdog reports a timeout when the target clock stalls and no measurement finishes. The target counter saturates instead of wrapping. After enabling, the first two results are dropped, because the first target window is only partly counted.

Configuration consists of the enable and the two bounds. It is written through a simple strobe port and can be frozen by a lock bit. Only reset undoes the lock.

Top module: `refwin_freq_checker`

## Requirements
- R1: With the checker enabled, a window count that lies within [lower, upper] (inclusive) produces a result pulse on `meas_valid_o` with `meas_class_o` = 0 (okay), and no error flag is set.
- R2: A window count below the lower bound produces class 1 (slow) and sets `err_slow_o`.
- R3: A window count above the upper bound produces class 2 (fast) and sets `err_fast_o`.
- R4: The target counter saturates at its all-ones value and marks the window as overflowed. An overflowed window is graded fast (class 2) even when the upper bound is the all-ones value.
- R5: While enabled, if no measurement completes for TIMEOUT_CYC (default 8) reference cycles, `err_timeout_o` is set. In normal operation it stays clear.
- R6: The error flags are sticky. `clr_i` is write-one-to-clear: bit 0 clears slow, bit 1 clears fast and bit 2 clears timeout. If a new error and a clear arrive in the same cycle, the error wins.
- R7: `alert_o` pulses for one reference cycle on every slow, fast or timeout event.
- R8: While disabled, the checker produces no results and sets no flags, and the timeout watchdog is held cleared even if the target clock is stopped.
- R9: Once `cfg_lock_i` has been seen, `locked_o` stays high and configuration writes are ignored until reset.
- R10: Out of reset, the enable is 0, the lower bound is 0, the upper bound is all ones, the lock is clear, all flags are clear and no alert is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Always-on reference clock |
| rst_ref_ni | input | 1 | Asynchronous active-low reset, reference domain |
| clk_tgt_i | input | 1 | Clock under measurement |
| rst_tgt_ni | input | 1 | Asynchronous active-low reset, target domain |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_lo_i | input | CNT_W | Lower bound to write |
| cfg_hi_i | input | CNT_W | Upper bound to write |
| cfg_lock_i | input | 1 | Sets the configuration lock |
| clr_i | input | 3 | Write-one-to-clear: bit 0 slow, bit 1 fast, bit 2 timeout |
| en_o | output | 1 | Current enable |
| lo_o | output | CNT_W | Current lower bound |
| hi_o | output | CNT_W | Current upper bound |
| locked_o | output | 1 | Configuration lock state |
| meas_valid_o | output | 1 | One-cycle pulse per graded measurement |
| meas_class_o | output | 2 | Grade: 0 okay, 1 slow, 2 fast |
| err_slow_o | output | 1 | Sticky slow flag |
| err_fast_o | output | 1 | Sticky fast flag |
| err_timeout_o | output | 1 | Sticky timeout flag |
| alert_o | output | 1 | Recoverable alert pulse |

## Verification
The target runs at 20 cycles per reference window. The bounds are moved so that this single count falls inside the interval, below it and above it, which separates the three grade decisions. Lengthening the reference window to 50 target cycles with a 5-bit counter and an all-ones upper bound isolates the saturation path: a wrapping counter would instead report okay. Stopping the target clock while enabled triggers the timeout. Stopping it while disabled, with slow-provoking bounds, shows that the enable gates both grading and the watchdog.

// File: rtl/freqchk_pkg.sv
package freqchk_pkg;
  typedef enum logic [1:0] {
    CLS_OK   = 2'd0,
    CLS_SLOW = 2'd1,
    CLS_FAST = 2'd2
  } meas_cls_e;

  typedef enum int unsigned {
    FLG_SLOW = 0,
    FLG_FAST = 1,
    FLG_TMO  = 2
  } flag_idx_e;
endpackage

// File: rtl/freqchk_sync.sv
module freqchk_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/freqchk_rst_sync.sv
module freqchk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/freqchk_tgt_counter.sv
module freqchk_tgt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_s_i,
  input  logic             mark_s_i,
  input  logic             ack_s_i,
  output logic             done_tgl_o,
  output logic [CNT_W-1:0] hold_cnt_o,
  output logic             hold_ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, hold_cnt_q, hold_cnt_d;
  logic             ovf_q, ovf_d, hold_ovf_q, hold_ovf_d;
  logic             mark_prev_q, done_q, done_d;
  logic             mark_edge, hold_free;

  assign mark_edge = mark_s_i ^ mark_prev_q;
  assign hold_free = (ack_s_i == done_q);

  always_comb begin
    cnt_d      = cnt_q;
    ovf_d      = ovf_q;
    hold_cnt_d = hold_cnt_q;
    hold_ovf_d = hold_ovf_q;
    done_d     = done_q;
    if (!en_s_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (mark_edge) begin
      if (hold_free) begin
        hold_cnt_d = cnt_q;
        hold_ovf_d = ovf_q;
        done_d     = ~done_q;
      end
      cnt_d = CNT_W'(1);
      ovf_d = 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      ovf_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      ovf_q       <= 1'b0;
      hold_cnt_q  <= '0;
      hold_ovf_q  <= 1'b0;
      done_q      <= 1'b0;
      mark_prev_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      ovf_q       <= ovf_d;
      hold_cnt_q  <= hold_cnt_d;
      hold_ovf_q  <= hold_ovf_d;
      done_q      <= done_d;
      mark_prev_q <= mark_s_i;
    end
  end

  assign done_tgl_o = done_q;
  assign hold_cnt_o = hold_cnt_q;
  assign hold_ovf_o = hold_ovf_q;
endmodule

// File: rtl/freqchk_ref_ctrl.sv
module freqchk_ref_ctrl
  import freqchk_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 8,
  parameter int SKIP_CNT    = 2,
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1),
  localparam int SKIP_W     = $clog2(SKIP_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [CNT_W-1:0] cfg_lo_i,
  input  logic [CNT_W-1:0] cfg_hi_i,
  input  logic             cfg_lock_i,
  input  logic [2:0]       clr_i,
  input  logic             done_s_i,
  input  logic [CNT_W-1:0] hold_cnt_i,
  input  logic             hold_ovf_i,
  output logic             mark_tgl_o,
  output logic             ack_tgl_o,
  output logic             en_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             locked_o,
  output logic             meas_valid_o,
  output meas_cls_e        meas_class_o,
  output logic [2:0]       flags_o,
  output logic             alert_o,
  output logic [TO_W-1:0]  to_cnt_o
);
  logic             en_q, en_d, lock_q, lock_d;
  logic [CNT_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             mark_q, mark_d, ack_q, ack_d, done_prev_q;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [TO_W-1:0]  to_q, to_d;
  logic [2:0]       flg_q, flg_d, evt;
  logic             valid_q, valid_d, alert_q, alert_d;
  meas_cls_e        cls_q, cls_d, grade;
  logic             done_edge, eval;

  assign done_edge = done_s_i ^ done_prev_q;
  assign eval      = en_q && done_edge && (skip_q == '0);

  always_comb begin
    if (hold_ovf_i || (hold_cnt_i > hi_q)) begin
      grade = CLS_FAST;
    end else if (hold_cnt_i < lo_q) begin
      grade = CLS_SLOW;
    end else begin
      grade = CLS_OK;
    end
  end

  always_comb begin
    en_d   = en_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    lock_d = lock_q | cfg_lock_i;
    if (cfg_we_i && !lock_q) begin
      en_d = cfg_en_i;
      lo_d = cfg_lo_i;
      hi_d = cfg_hi_i;
    end

    mark_d = en_q ? ~mark_q : mark_q;
    ack_d  = done_edge ? done_s_i : ack_q;

    skip_d = skip_q;
    if (!en_q) begin
      skip_d = SKIP_W'(SKIP_CNT);
    end else if (done_edge && (skip_q != '0)) begin
      skip_d = skip_q - SKIP_W'(1);
    end

    evt = 3'b000;
    to_d = to_q;
    if (!en_q || done_edge) begin
      to_d = '0;
    end else if (to_q == TO_W'(TIMEOUT_CYC - 1)) begin
      to_d = '0;
      evt[FLG_TMO] = 1'b1;
    end else begin
      to_d = to_q + TO_W'(1);
    end

    valid_d = eval;
    cls_d   = eval ? grade : cls_q;
    evt[FLG_SLOW] = eval && (grade == CLS_SLOW);
    evt[FLG_FAST] = eval && (grade == CLS_FAST);

    flg_d   = (flg_q & ~clr_i) | evt;
    alert_d = |evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '1;
      lock_q      <= 1'b0;
      mark_q      <= 1'b0;
      ack_q       <= 1'b0;
      done_prev_q <= 1'b0;
      skip_q      <= SKIP_W'(SKIP_CNT);
      to_q        <= '0;
      flg_q       <= '0;
      valid_q     <= 1'b0;
      cls_q       <= CLS_OK;
      alert_q     <= 1'b0;
    end else begin
      en_q        <= en_d;
      lo_q        <= lo_d;
      hi_q        <= hi_d;
      lock_q      <= lock_d;
      mark_q      <= mark_d;
      ack_q       <= ack_d;
      done_prev_q <= done_s_i;
      skip_q      <= skip_d;
      to_q        <= to_d;
      flg_q       <= flg_d;
      valid_q     <= valid_d;
      cls_q       <= cls_d;
      alert_q     <= alert_d;
    end
  end

  assign mark_tgl_o   = mark_q;
  assign ack_tgl_o    = ack_q;
  assign en_o         = en_q;
  assign lo_o         = lo_q;
  assign hi_o         = hi_q;
  assign locked_o     = lock_q;
  assign meas_valid_o = valid_q;
  assign meas_class_o = cls_q;
  assign flags_o      = flg_q;
  assign alert_o      = alert_q;
  assign to_cnt_o     = to_q;
endmodule

// File: rtl/refwin_freq_checker.sv
module refwin_freq_checker
  import freqchk_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_ref_i,
  input  logic             rst_ref_ni,
  input  logic             clk_tgt_i,
  input  logic             rst_tgt_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [CNT_W-1:0] cfg_lo_i,
  input  logic [CNT_W-1:0] cfg_hi_i,
  input  logic             cfg_lock_i,
  input  logic [2:0]       clr_i,
  output logic             en_o,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             locked_o,
  output logic             meas_valid_o,
  output logic [1:0]       meas_class_o,
  output logic             err_slow_o,
  output logic             err_fast_o,
  output logic             err_timeout_o,
  output logic             alert_o
);
  logic             rst_ref_n, rst_tgt_n;
  logic             mark_tgl, ack_tgl, done_tgl, done_s;
  logic [2:0]       to_tgt_s;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_ovf;
  logic [2:0]       flags;
  meas_cls_e        cls;
  logic [TO_W-1:0]  ref_to_cnt;

  freqchk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ref (
    .clk_i(clk_ref_i), .rst_ni(rst_ref_ni), .rst_no(rst_ref_n)
  );
  freqchk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_tgt (
    .clk_i(clk_tgt_i), .rst_ni(rst_tgt_ni), .rst_no(rst_tgt_n)
  );

  freqchk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync_to_tgt (
    .clk_i(clk_tgt_i), .rst_ni(rst_tgt_n),
    .d_i({en_o, mark_tgl, ack_tgl}), .q_o(to_tgt_s)
  );
  freqchk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_to_ref (
    .clk_i(clk_ref_i), .rst_ni(rst_ref_n),
    .d_i(done_tgl), .q_o(done_s)
  );

  freqchk_tgt_counter #(.CNT_W(CNT_W)) u_tgt (
    .clk_i      (clk_tgt_i),
    .rst_ni     (rst_tgt_n),
    .en_s_i     (to_tgt_s[2]),
    .mark_s_i   (to_tgt_s[1]),
    .ack_s_i    (to_tgt_s[0]),
    .done_tgl_o (done_tgl),
    .hold_cnt_o (hold_cnt),
    .hold_ovf_o (hold_ovf)
  );

  freqchk_ref_ctrl #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ref (
    .clk_i        (clk_ref_i),
    .rst_ni       (rst_ref_n),
    .cfg_we_i     (cfg_we_i),
    .cfg_en_i     (cfg_en_i),
    .cfg_lo_i     (cfg_lo_i),
    .cfg_hi_i     (cfg_hi_i),
    .cfg_lock_i   (cfg_lock_i),
    .clr_i        (clr_i),
    .done_s_i     (done_s),
    .hold_cnt_i   (hold_cnt),
    .hold_ovf_i   (hold_ovf),
    .mark_tgl_o   (mark_tgl),
    .ack_tgl_o    (ack_tgl),
    .en_o         (en_o),
    .lo_o         (lo_o),
    .hi_o         (hi_o),
    .locked_o     (locked_o),
    .meas_valid_o (meas_valid_o),
    .meas_class_o (cls),
    .flags_o      (flags),
    .alert_o      (alert_o),
    .to_cnt_o     (ref_to_cnt)
  );

  assign meas_class_o  = cls;
  assign err_slow_o    = flags[FLG_SLOW];
  assign err_fast_o    = flags[FLG_FAST];
  assign err_timeout_o = flags[FLG_TMO];
endmodule

// File: rtl/freqchk_checker.sv
module freqchk_checker #(
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 8,
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       clr_i,
  input logic             en_o,
  input logic [CNT_W-1:0] lo_o,
  input logic [CNT_W-1:0] hi_o,
  input logic             locked_o,
  input logic             meas_valid_o,
  input logic [1:0]       meas_class_o,
  input logic             err_slow_o,
  input logic             err_fast_o,
  input logic             err_timeout_o,
  input logic             alert_o,
  input logic [TO_W-1:0]  to_cnt
);
  p_slow_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_o && meas_class_o == 2'd1) |-> err_slow_o);
  p_fast_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_o && meas_class_o == 2'd2) |-> err_fast_o);
  p_legal_class_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |-> (meas_class_o != 2'd3));
  p_watchdog_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_cnt < TO_W'(TIMEOUT_CYC));
  p_sticky_slow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_slow_o && !clr_i[0]) |=> err_slow_o);
  p_sticky_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_fast_o && !clr_i[1]) |=> err_fast_o);
  p_sticky_tmo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_timeout_o && !clr_i[2]) |=> err_timeout_o);
  p_alert_on_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(err_slow_o) || $rose(err_fast_o) || $rose(err_timeout_o)) |-> alert_o);
  p_quiet_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> !meas_valid_o);
  p_no_flag_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> !($rose(err_slow_o) || $rose(err_fast_o) || $rose(err_timeout_o)));
  p_lock_stays_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  p_lock_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> ($stable(en_o) && $stable(lo_o) && $stable(hi_o)));
endmodule

bind refwin_freq_checker freqchk_checker #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i         (clk_ref_i),
  .rst_ni        (rst_ref_ni),
  .clr_i         (clr_i),
  .en_o          (en_o),
  .lo_o          (lo_o),
  .hi_o          (hi_o),
  .locked_o      (locked_o),
  .meas_valid_o  (meas_valid_o),
  .meas_class_o  (meas_class_o),
  .err_slow_o    (err_slow_o),
  .err_fast_o    (err_fast_o),
  .err_timeout_o (err_timeout_o),
  .alert_o       (alert_o),
  .to_cnt        (ref_to_cnt)
);

// File: tb/test_refwin_freq_checker.sv
module test_refwin_freq_checker;
  localparam int CW = 5;
  localparam int TMO = 8;

  logic clk_ref = 1'b0, clk_tgt = 1'b0, tgt_run = 1'b1;
  logic rst_ref_n = 1'b0, rst_tgt_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_lock = 1'b0;
  logic [CW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [2:0] clr = 3'b000;
  logic en_o, locked_o, meas_valid_o, err_slow_o, err_fast_o, err_timeout_o, alert_o;
  logic [CW-1:0] lo_o, hi_o;
  logic [1:0] meas_class_o;
  time ref_half = 80ns;

  int n_tests = 0, n_fail = 0, alert_cnt = 0, valid_cnt = 0;
  bit sb_on = 1'b0;
  int exp_q[$];
  string sb_tag = "";

  always #4ns clk_tgt = tgt_run ? ~clk_tgt : 1'b0;
  initial begin
    #3ns;
    forever #(ref_half) clk_ref = ~clk_ref;
  end

  refwin_freq_checker #(.CNT_W(CW), .TIMEOUT_CYC(TMO)) i_refwin_freq_checker (
    .clk_ref_i(clk_ref), .rst_ref_ni(rst_ref_n), .clk_tgt_i(clk_tgt), .rst_tgt_ni(rst_tgt_n),
    .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi),
    .cfg_lock_i(cfg_lock), .clr_i(clr), .en_o(en_o), .lo_o(lo_o), .hi_o(hi_o),
    .locked_o(locked_o), .meas_valid_o(meas_valid_o), .meas_class_o(meas_class_o),
    .err_slow_o(err_slow_o), .err_fast_o(err_fast_o), .err_timeout_o(err_timeout_o),
    .alert_o(alert_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected grades as results appear
  always @(negedge clk_ref) begin
    if (alert_o) alert_cnt++;
    if (meas_valid_o) begin
      valid_cnt++;
      if (sb_on && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check(int'(meas_class_o) == e, sb_tag, "grade", int'(meas_class_o), e);
      end
    end
  end

  task automatic ref_wait(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic cfg_write(input logic e, input int lo, input int hi);
    @(negedge clk_ref);
    cfg_we = 1'b1; cfg_en = e; cfg_lo = CW'(lo); cfg_hi = CW'(hi);
    @(negedge clk_ref);
    cfg_we = 1'b0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk_ref);
    clr = m;
    @(negedge clk_ref);
    clr = 3'b000;
  endtask

  // driver: configure, settle, push expected grades, wait for the monitor
  task automatic run_phase(input int lo, input int hi, input int exp, input string tag);
    sb_on = 1'b0;
    cfg_write(1'b1, lo, hi);
    ref_wait(14);
    clear(3'b111);
    exp_q.delete();
    repeat (4) exp_q.push_back(exp);
    alert_cnt = 0;
    sb_tag = tag;
    sb_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk_ref);
    end
    sb_on = 1'b0;
    check(exp_q.size() == 0, tag, "results produced", 4 - exp_q.size(), 4);
  endtask

  initial begin
    #1500us;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000ns;
    rst_ref_n = 1'b1; rst_tgt_n = 1'b1;
    ref_wait(4);
    // R10 reset values
    check(en_o == 1'b0, "R10", "enable", en_o, 0);
    check(lo_o == '0, "R10", "lower", lo_o, 0);
    check(hi_o == '1, "R10", "upper", hi_o, 31);
    check(locked_o == 1'b0, "R10", "lock", locked_o, 0);
    check({err_slow_o, err_fast_o, err_timeout_o, alert_o} == 4'b0, "R10", "flags",
          {err_slow_o, err_fast_o, err_timeout_o, alert_o}, 0);

    // R1: 20 in [15,25]
    run_phase(15, 25, 0, "R1");
    check({err_slow_o, err_fast_o} == 2'b00, "R1", "no flags", {err_slow_o, err_fast_o}, 0);
    check(alert_cnt == 0, "R7", "no alert when okay", alert_cnt, 0);
    check(err_timeout_o == 1'b0, "R5", "no timeout while running", err_timeout_o, 0);

    // R2: 20 < 25
    run_phase(25, 31, 1, "R2");
    check(err_slow_o == 1'b1, "R2", "slow flag", err_slow_o, 1);
    check(err_fast_o == 1'b0, "R2", "fast flag clear", err_fast_o, 0);
    check(alert_cnt >= 4, "R7", "alert per slow event", alert_cnt, 4);

    // R6: sticky and per-bit clear
    cfg_write(1'b1, 15, 25);
    ref_wait(14);
    check(err_slow_o == 1'b1, "R6", "slow stays set", err_slow_o, 1);
    clear(3'b010);
    check(err_slow_o == 1'b1, "R6", "other bit leaves slow", err_slow_o, 1);
    clear(3'b001);
    check(err_slow_o == 1'b0, "R6", "slow cleared", err_slow_o, 0);

    // R3: 20 > 15
    run_phase(5, 15, 2, "R3");
    check(err_fast_o == 1'b1, "R3", "fast flag", err_fast_o, 1);
    check(alert_cnt >= 4, "R7", "alert per fast event", alert_cnt, 4);

    // R4: 20 with full range is okay; 50 saturates and is fast
    run_phase(0, 31, 0, "R4");
    ref_half = 200ns;
    run_phase(0, 31, 2, "R4");
    check(err_fast_o == 1'b1, "R4", "overflow fast flag", err_fast_o, 1);
    ref_half = 80ns;
    run_phase(15, 25, 0, "R1");

    // R5: target stalls while enabled
    clear(3'b111);
    tgt_run = 1'b0;
    alert_cnt = 0;
    ref_wait(24);
    check(err_timeout_o == 1'b1, "R5", "timeout flag", err_timeout_o, 1);
    check(alert_cnt >= 1, "R7", "alert on timeout", alert_cnt, 1);
    tgt_run = 1'b1;

    // R8: disabled with slow bounds and stalled target
    cfg_write(1'b0, 25, 31);
    ref_wait(10);
    clear(3'b111);
    valid_cnt = 0;
    alert_cnt = 0;
    ref_wait(15);
    tgt_run = 1'b0;
    ref_wait(25);
    tgt_run = 1'b1;
    ref_wait(5);
    check(valid_cnt == 0, "R8", "results while disabled", valid_cnt, 0);
    check({err_slow_o, err_fast_o, err_timeout_o} == 3'b0, "R8", "flags while disabled",
          {err_slow_o, err_fast_o, err_timeout_o}, 0);
    check(alert_cnt == 0, "R8", "alerts while disabled", alert_cnt, 0);

    // R9: lock freezes configuration
    @(negedge clk_ref); cfg_lock = 1'b1;
    @(negedge clk_ref); cfg_lock = 1'b0;
    check(locked_o == 1'b1, "R9", "lock set", locked_o, 1);
    cfg_write(1'b1, 3, 9);
    ref_wait(2);
    check(en_o == 1'b0, "R9", "enable frozen", en_o, 0);
    check(lo_o == CW'(25), "R9", "lower frozen", lo_o, 25);
    check(hi_o == CW'(31), "R9", "upper frozen", hi_o, 31);
    check(locked_o == 1'b1, "R9", "lock held", locked_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule